// File: doc/BRIEF.md
# Iterative Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (32 by default) and returns the full `2*WIDTH`-bit product. It uses a single adder one bit wider than an operand and one double-width accumulator. A one-cycle `start` pulse captures both operands. The multiplicand is kept in its own register. The multiplier goes into the lower half of the accumulator, and the upper half is cleared.

On each following clock the block runs one iteration. It checks the accumulator's least significant bit. When that bit is 1, it adds the multiplicand to the upper half. The adder's result, including its carry, is then written back with the whole accumulator shifted right by one place. The carry lands in the top bit.

After `WIDTH` iterations the accumulator holds the product and `done` rises. `done` stays high, and the product stays unchanged, until the next `start`. A `start` that arrives while iterations are in progress is ignored.

Top module: `shiftadd_mul`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle, and after that edge `done` reads 0 and `product` reads 0.
- R2: When `start` is high at an edge while the block is idle or finished, both operands are captured. After that edge `done` reads 0 and `product` reads the multiplier zero-extended, with zeros in the upper `WIDTH` bits.
- R3: `done` is 0 after each of the first `WIDTH-1` edges that follow the load edge. It reads 1 after the `WIDTH`-th such edge.
- R4: When `done` rises, `product` equals the unsigned product of the two captured operands over all `2*WIDTH` bits, including carries out of the upper half (for example, all-ones times all-ones).
- R5: Each iteration shifts the accumulator right by one bit. After the first iteration, bits `WIDTH-2:0` of `product` equal the multiplier shifted right by one.
- R6: A `start` that arrives while iterations are running is ignored. The same holds on the final iteration's edge. Operand input changes after the load edge do not affect the result.
- R7: While `done` is high and `start` is low, `done` stays high and `product` holds its value. A `start` seen while finished begins a new product.
- R8: A zero multiplicand or a zero multiplier yields a zero product after the usual number of iterations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load pulse; takes effect only when not iterating |
| mcand | input | WIDTH | Multiplicand, sampled with `start` |
| mplier | input | WIDTH | Multiplier, sampled with `start` |
| product | output | 2*WIDTH | Accumulator contents; full product once `done` is high |
| done | output | 1 | High from completion until the next load |

## Verification
Two events can share a clock edge. A new `start` can arrive on the edge of the final iteration, and a new load can be requested while `done` is already high. The sweep provokes the first case by raising `start` with different operands on every possible iteration edge, including the last. It then judges that `done` still rises on time and that the product matches the first operands. The second case is exercised on every back-to-back run, where the next `start` is sampled while `done` is high. Here the bench checks that `done` falls and that the accumulator reloads on that same edge.

// File: rtl/shiftadd_mul_pkg.sv
// Package: shared types for the shift-add multiplier.
// Assumes nothing beyond a standard SystemVerilog compile order.
package shiftadd_mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_e;
endpackage

// File: rtl/shiftadd_mul_ctrl.sv
// Controller: sequences load, WIDTH iterations and completion.
// Assumes WIDTH >= 2. start is ignored while in ST_RUN.
module shiftadd_mul_ctrl
    import shiftadd_mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic fin
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    mul_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;

    assign busy = (state_q == ST_RUN);
    assign fin  = (state_q == ST_FIN);
    assign load = start && !busy;
    assign step = busy;

    // Next-state selection for the iteration sequencer.
    always_comb begin
        state_d = state_q;
        if (load)
            state_d = ST_RUN;
        else if (busy && cnt_q == LAST)
            state_d = ST_FIN;
    end

    // State and iteration counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load)
                cnt_q <= '0;
            else if (busy)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the counter never passes the final iteration index while running.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= LAST));

    // R6: a running product keeps running until its last iteration, whatever start does.
    a_r6_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != LAST) |=> busy);

    // R3: the last iteration leads straight to completion.
    a_r3_last_to_fin: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == LAST) |=> fin);
endmodule

// File: rtl/shiftadd_mul_adder.sv
// Conditional adder: adds the addend to the accumulator's upper half when
// enabled. The result is one bit wider than an operand, so the carry is kept.
module shiftadd_mul_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] upper,
    input  logic [WIDTH-1:0] addend,
    input  logic             en,
    output logic [WIDTH:0]   sum
);
    logic [WIDTH-1:0] gated;

    // Gate the addend with the tested bit, then form the carry-keeping sum.
    always_comb begin
        gated = en ? addend : '0;
        sum   = {1'b0, upper} + {1'b0, gated};
    end
endmodule

// File: rtl/shiftadd_mul_dp.sv
// Datapath: multiplicand register plus the double-width accumulator that
// holds the multiplier in its low half and the growing product.
// Assumes load and step are never high together (ensured by the controller).
module shiftadd_mul_dp #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] acc
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mc_q;
    logic [PW-1:0]    acc_q;
    logic [WIDTH:0]   sum;

    shiftadd_mul_adder #(.WIDTH(WIDTH)) u_add (
        .upper (acc_q[PW-1:WIDTH]),
        .addend(mc_q),
        .en    (acc_q[0]),
        .sum   (sum)
    );

    // Accumulator and multiplicand: load, or add-and-shift per iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            mc_q  <= '0;
        end else if (load) begin
            acc_q <= {{WIDTH{1'b0}}, mplier};
            mc_q  <= mcand;
        end else if (step) begin
            acc_q <= {sum, acc_q[WIDTH-1:1]};
        end
    end

    assign acc = acc_q;

    // R2: a load leaves the multiplier in the low half with the high half clear.
    a_r2_load_layout: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_q == {{WIDTH{1'b0}}, $past(mplier)}));

    // R5: each iteration moves the low bits down by exactly one place.
    a_r5_shift_low: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (acc_q[WIDTH-2:0] == $past(acc_q[WIDTH-1:1])));

    // R4: without an add, no carry can reach the top bit.
    a_r4_no_add_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !acc_q[0]) |=> !acc_q[PW-1]);
endmodule

// File: rtl/shiftadd_mul.sv
// Top: iterative unsigned multiplier, one add-and-shift iteration per clock.
// Assumes a synchronous active-low reset and a single-cycle start pulse.
module shiftadd_mul #(
    parameter int WIDTH = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WIDTH-1:0]     mcand,
    input  logic [WIDTH-1:0]     mplier,
    output logic [2*WIDTH-1:0]   product,
    output logic                 done
);
    logic load, step, busy, fin;

    shiftadd_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .load (load),
        .step (step),
        .busy (busy),
        .fin  (fin)
    );

    shiftadd_mul_dp #(.WIDTH(WIDTH)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .mcand (mcand),
        .mplier(mplier),
        .acc   (product)
    );

    assign done = fin;

    // R1: reset clears completion and the accumulator.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!done && product == '0));

    // R7: completion and the result hold until a new start.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product)));

    // R7: a start while finished clears completion on the next cycle.
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    // R6: done never shows while iterating.
    a_r6_not_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

// File: tb/sim_shiftadd_mul.sv
// Exhaustive sweep of a narrow instance; expected products computed arithmetically.
module sim_shiftadd_mul;
    localparam int W      = 6;
    localparam int PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   mcand = '0;
    logic [W-1:0]   mplier = '0;
    logic [2*W-1:0] product;
    logic           done;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    shiftadd_mul #(.WIDTH(W)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mcand  (mcand),
        .mplier (mplier),
        .product(product),
        .done   (done)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // One product; inj selects the iteration edge (1..W) that also sees start.
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input int inj);
        logic [2*W-1:0] exp;
        string tag;
        exp = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        tag = (a == 0 || b == 0) ? "R8" : "R4";
        start = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0; mcand = ~a; mplier = ~b;
        check(product == {{W{1'b0}}, b}, "R2", 64'(product), 64'(b));
        check(done == 1'b0, "R2", 64'(done), 64'd0);
        for (int i = 1; i <= W; i++) begin
            if (i == inj) begin
                start = 1'b1; mcand = b; mplier = a ^ 6'h15;
            end
            @(negedge clk);
            start = 1'b0;
            if (i == 1)
                check(product[W-2:0] == (W-1)'(b >> 1), "R5",
                      64'(product[W-2:0]), 64'(b >> 1));
            if (i < W)
                check(done == 1'b0, "R3", 64'(done), 64'd0);
            else begin
                check(done == 1'b1, "R3", 64'(done), 64'd1);
                check(product == exp, (inj != 0) ? "R6" : tag, 64'(product), 64'(exp));
            end
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state after reset
        check(done == 1'b0, "R1", 64'(done), 64'd0);
        check(product == '0, "R1", 64'(product), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1", 64'(done), 64'd0);
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                int inj;
                inj = ((a + b) % 5 == 0) ? ((a + b) % W) + 1 : 0;
                run(W'(a), W'(b), inj);
                if (a == b) begin
                    logic [2*W-1:0] held;
                    held = product;
                    for (int k = 0; k < 3; k++) begin
                        @(negedge clk);
                        check(done == 1'b1, "R7", 64'(done), 64'd1);
                        check(product == held, "R7", 64'(product), 64'(held));
                    end
                end
            end
        end
        // R6: start on the final iteration edge with all-ones operands (carry case)
        run('1, '1, W);
        // R1: reset in the middle of a run
        start = 1'b1; mcand = 6'h2b; mplier = 6'h3d;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R1", 64'(done), 64'd0);
        check(product == '0, "R1", 64'(product), 64'd0);
        rst_n = 1'b1;
        repeat (W + 2) @(negedge clk);
        check(done == 1'b0, "R1", 64'(done), 64'd0);
        finish_run();
    end
endmodule